// File: doc/BRIEF.md
# Carry-Preserving Increment Unit

This block is one registered slice of an integer execution datapath. It adds one to a 64-bit operand at a chosen operand size of 8, 16, 32 or 64 bits, and it returns the incremented value together with a rewritten status-flag word. The carry flag is deliberately left as it came in, so a loop counter can be stepped without losing a carry produced by earlier arithmetic. Every other arithmetic flag is derived again from the new value.

A request is a single cycle with `in_valid` high that carries the operand, a size code and the current flag word. The answer appears on the registered outputs one clock later, marked by `out_valid`. When no request is present the outputs keep their last value. The 8-bit and 16-bit sizes leave the register bits above the operand width intact. The 32-bit size clears bits 63:32, and the 64-bit size writes the whole register.

Top module: `incr_alu`

## Requirements
- R1: The low W bits of `out_result` equal the low W bits of the operand plus one, wrapping modulo 2^W. W is 8, 16, 32 or 64 for size codes 0, 1, 2 and 3.
- R2: The carry flag, bit 0 of the flag word, is copied from the input flag word whatever the result.
- R3: The overflow flag, bit 11, is set exactly when the low W operand bits held the largest positive signed value of that width (7Fh for size 0).
- R4: The sign flag, bit 7, equals bit W-1 of the result.
- R5: The zero flag, bit 6, is set exactly when the low W result bits are all zero.
- R6: The auxiliary-carry flag, bit 4, is set exactly when operand bits 3:0 were all ones.
- R7: The parity flag, bit 2, is set exactly when result bits 7:0 hold an even number of ones.
- R8: For size 2, `out_result[63:32]` is zero. For sizes 0 and 1, the result bits above W equal the operand bits above W.
- R9: Every flag-word bit other than bits 0, 2, 4, 6, 7 and 11 is copied from the input flag word.
- R10: `out_valid` and the data for a request appear on the clock edge after the one that samples `in_valid`. Reset clears `out_valid`, `out_result` and `out_flags` to zero.
- R11: A cycle with `in_valid` low leaves `out_result` and `out_flags` unchanged and drives `out_valid` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_operand | input | 64 | Destination register value before the increment |
| in_size | input | 2 | Operand size code: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits |
| in_flags | input | 32 | Current flag word |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Incremented register value |
| out_flags | output | 32 | Updated flag word |

## Verification
Each result field and each flag of a request is due exactly one clock after the edge that sampled it, and all of them arrive together with `out_valid`. The bench drives requests on the falling edge and pushes the expected value onto a queue at that moment. A monitor on the next falling edge pops one entry for every cycle in which `out_valid` is high. A result that arrives with no entry waiting, or an entry still queued once the stream has drained, counts as a latency failure. Idle cycles are checked one falling edge after `in_valid` drops, to confirm that the outputs held their values.

// File: rtl/incr_pkg.sv
package incr_pkg;

  localparam int DATA_W  = 64;
  localparam int N_SIZES = 4;

  // flag word bit positions; downstream logic decodes these
  localparam int POS_CY  = 0;
  localparam int POS_PAR = 2;
  localparam int POS_AUX = 4;
  localparam int POS_ZR  = 6;
  localparam int POS_SG  = 7;
  localparam int POS_OV  = 11;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } opsize_e;

  // recomputed flag events of one increment
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
  } inc_evt_t;

  function automatic int lane_width(input int idx);
    return 8 << idx;
  endfunction

  // ones above the operand width where the register keeps its old bits
  function automatic logic [DATA_W-1:0] keep_mask(input opsize_e s);
    logic [DATA_W-1:0] m;
    case (s)
      SZ_BYTE: m = {{(DATA_W-8){1'b1}}, 8'h00};
      SZ_HALF: m = {{(DATA_W-16){1'b1}}, 16'h0000};
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic even_ones8(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [31:0] arith_bits();
    logic [31:0] m;
    m = '0;
    m[POS_CY]  = 1'b1;
    m[POS_PAR] = 1'b1;
    m[POS_AUX] = 1'b1;
    m[POS_ZR]  = 1'b1;
    m[POS_SG]  = 1'b1;
    m[POS_OV]  = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/incr_lane.sv
module incr_lane #(
  parameter int W      = 8,
  parameter int OUT_W  = 64
) (
  input  logic [W-1:0]     op,
  output logic [OUT_W-1:0] sum_ext,
  output logic             ovf,
  output logic             sgn,
  output logic             zro
);
  localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] ONE     = W'(1);

  logic [W-1:0] sum;

  assign sum     = op + ONE;
  assign sum_ext = OUT_W'(sum);
  assign ovf     = (op == MAX_POS);
  assign sgn     = sum[W-1];
  assign zro     = (sum == '0);
endmodule

// File: rtl/incr_select.sv
module incr_select
  import incr_pkg::*;
#(
  parameter int NS = N_SIZES,
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0]         op,
  input  opsize_e               size,
  input  logic [NS-1:0][DW-1:0] lane_sum,
  input  logic [NS-1:0]         lane_ovf,
  input  logic [NS-1:0]         lane_sgn,
  input  logic [NS-1:0]         lane_zro,
  output logic [DW-1:0]         result,
  output inc_evt_t              evt
);
  logic [DW-1:0] kept;

  assign kept   = op & keep_mask(size);
  assign result = kept | lane_sum[size];

  always_comb begin
    evt.ovf = lane_ovf[size];
    evt.sgn = lane_sgn[size];
    evt.zro = lane_zro[size];
    evt.aux = &op[3:0];
    evt.par = even_ones8(result[7:0]);
  end
endmodule

// File: rtl/incr_flag_merge.sv
module incr_flag_merge
  import incr_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags_in,
  input  inc_evt_t          evt,
  output logic [FLAG_W-1:0] flags_out
);
  always_comb begin
    flags_out          = flags_in;
    flags_out[POS_PAR] = evt.par;
    flags_out[POS_AUX] = evt.aux;
    flags_out[POS_ZR]  = evt.zro;
    flags_out[POS_SG]  = evt.sgn;
    flags_out[POS_OV]  = evt.ovf;
  end
endmodule

// File: rtl/incr_out_reg.sv
module incr_out_reg #(
  parameter int DW     = 64,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DW-1:0]     d_result,
  input  logic [FLAG_W-1:0] d_flags,
  output logic              q_valid,
  output logic [DW-1:0]     q_result,
  output logic [FLAG_W-1:0] q_flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid  <= 1'b0;
      q_result <= '0;
      q_flags  <= '0;
    end else begin
      q_valid <= load;
      if (load) begin
        q_result <= d_result;
        q_flags  <= d_flags;
      end
    end
  end
endmodule

// File: rtl/incr_alu.sv
module incr_alu
  import incr_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_operand,
  input  logic [1:0]        in_size,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_valid,
  output logic [63:0]       out_result,
  output logic [FLAG_W-1:0] out_flags
);
  localparam int NS = N_SIZES;
  localparam int DW = DATA_W;

  logic [NS-1:0][DW-1:0] lane_sum;
  logic [NS-1:0]         lane_ovf;
  logic [NS-1:0]         lane_sgn;
  logic [NS-1:0]         lane_zro;

  // named internal events
  logic [DW-1:0]     nxt_result;
  inc_evt_t          nxt_evt;
  logic [FLAG_W-1:0] nxt_flags;
  opsize_e           size_e;

  assign size_e = opsize_e'(in_size);

  for (genvar g = 0; g < NS; g++) begin : g_lane
    localparam int LW = lane_width(g);
    incr_lane #(.W(LW), .OUT_W(DW)) u_lane (
      .op      (in_operand[LW-1:0]),
      .sum_ext (lane_sum[g]),
      .ovf     (lane_ovf[g]),
      .sgn     (lane_sgn[g]),
      .zro     (lane_zro[g])
    );
  end

  incr_select #(.NS(NS), .DW(DW)) u_sel (
    .op       (in_operand),
    .size     (size_e),
    .lane_sum (lane_sum),
    .lane_ovf (lane_ovf),
    .lane_sgn (lane_sgn),
    .lane_zro (lane_zro),
    .result   (nxt_result),
    .evt      (nxt_evt)
  );

  incr_flag_merge #(.FLAG_W(FLAG_W)) u_merge (
    .flags_in  (in_flags),
    .evt       (nxt_evt),
    .flags_out (nxt_flags)
  );

  incr_out_reg #(.DW(DW), .FLAG_W(FLAG_W)) u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (in_valid),
    .d_result (nxt_result),
    .d_flags  (nxt_flags),
    .q_valid  (out_valid),
    .q_result (out_result),
    .q_flags  (out_flags)
  );
endmodule

// File: rtl/incr_alu_chk.sv
module incr_alu_chk
  import incr_pkg::*;
#(
  parameter int FLAG_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [63:0]       in_operand,
  input logic [1:0]        in_size,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_valid,
  input logic [63:0]       out_result,
  input logic [FLAG_W-1:0] out_flags
);
  localparam logic [FLAG_W-1:0] ARITH_M = FLAG_W'(arith_bits());

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r11_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_result) && $stable(out_flags)));

  a_r2_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_flags[POS_CY] == $past(in_flags[POS_CY])));

  a_r9_other_bits: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (((out_flags ^ $past(in_flags)) & ~ARITH_M) == '0));

  a_r8_word_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd2) |=> (out_result[63:32] == 32'h0));

  a_r8_byte_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=> (out_result[63:8] == $past(in_operand[63:8])));

  a_r6_aux: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_flags[POS_AUX] == (&$past(in_operand[3:0]))));

  a_r7_parity: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_flags[POS_PAR] == ($countones(out_result[7:0]) % 2 == 0)));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0 && in_operand[7:0] != 8'h7F) |=> !out_flags[POS_OV]);

  a_r5_byte_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_size == 2'd0) |=> (out_flags[POS_ZR] == (out_result[7:0] == 8'h00)));
endmodule

bind incr_alu incr_alu_chk #(.FLAG_W(FLAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_operand (in_operand),
  .in_size    (in_size),
  .in_flags   (in_flags),
  .out_valid  (out_valid),
  .out_result (out_result),
  .out_flags  (out_flags)
);

// File: tb/tb_incr_alu.sv
module tb_incr_alu;
  localparam int B_CY = 0, B_PAR = 2, B_AUX = 4, B_ZR = 6, B_SG = 7, B_OV = 11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_operand = '0;
  logic [1:0]  in_size = '0;
  logic [31:0] in_flags = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic [31:0] out_flags;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  typedef struct {
    logic [63:0] res;
    logic [31:0] flg;
    int          w;
  } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  incr_alu dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_operand(in_operand),
    .in_size(in_size), .in_flags(in_flags), .out_valid(out_valid),
    .out_result(out_result), .out_flags(out_flags)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // independent reference for one request
  task automatic predict(input logic [63:0] op, input logic [1:0] sz,
                         input logic [31:0] fi, output exp_t e);
    int w;
    logic [63:0] m, low, opm;
    int ones;
    w    = 8 * (1 << sz);
    m    = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    opm  = op & m;
    low  = (opm + 64'd1) & m;
    e.w  = w;
    e.res = (sz >= 2) ? low : ((op & ~m) | low);
    e.flg = fi;
    e.flg[B_OV]  = (opm == (m >> 1));
    e.flg[B_SG]  = low[w-1];
    e.flg[B_ZR]  = (low == 64'd0);
    e.flg[B_AUX] = (op[3:0] == 4'hF);
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(low[i]);
    e.flg[B_PAR] = (ones % 2 == 0);
  endtask

  task automatic send(input logic [63:0] op, input logic [1:0] sz, input logic [31:0] fi);
    exp_t e;
    predict(op, sz, fi, e);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_size = sz; in_flags = fi;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_operand = {$urandom, $urandom};
      in_flags = $urandom;
    end
  endtask

  // monitor: the scoreboard pops one entry per valid result
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        check(0, "R10 result without request", 64'(out_valid), 64'd0);
      end else begin
        exp_t e;
        logic [63:0] m;
        e = sb.pop_front();
        m = (e.w == 64) ? {64{1'b1}} : ((64'd1 << e.w) - 64'd1);
        check((out_result & m) == (e.res & m), "R1 low result", out_result & m, e.res & m);
        check((out_result & ~m) == (e.res & ~m), "R8 upper bits", out_result, e.res);
        check(out_flags[B_CY] == e.flg[B_CY], "R2 carry", 64'(out_flags), 64'(e.flg));
        check(out_flags[B_OV] == e.flg[B_OV], "R3 overflow", 64'(out_flags), 64'(e.flg));
        check(out_flags[B_SG] == e.flg[B_SG], "R4 sign", 64'(out_flags), 64'(e.flg));
        check(out_flags[B_ZR] == e.flg[B_ZR], "R5 zero", 64'(out_flags), 64'(e.flg));
        check(out_flags[B_AUX] == e.flg[B_AUX], "R6 aux", 64'(out_flags), 64'(e.flg));
        check(out_flags[B_PAR] == e.flg[B_PAR], "R7 parity", 64'(out_flags), 64'(e.flg));
        check(out_flags == e.flg, "R9 whole flag word", 64'(out_flags), 64'(e.flg));
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] held_r;
    logic [31:0] held_f;
    repeat (3) @(negedge clk);
    check(!out_valid && out_result == 0 && out_flags == 0, "R10 reset state",
          {out_result[62:0], out_valid}, 64'd0);
    rst_n = 1'b1;

    // corner cases per size
    send(64'hAAAA_BBBB_CCDD_EE7F, 2'd0, 32'h0000_0001);   // R3 byte max positive
    send(64'h1234_5678_9ABC_DEFF, 2'd0, 32'hFFFF_FFFE);   // R5 byte wrap to zero
    send(64'h0000_0000_0000_000F, 2'd0, 32'h0000_0000);   // R6 aux
    send(64'hFFFF_FFFF_FFFF_7FFF, 2'd1, 32'h0000_0801);   // R3 half
    send(64'h5555_5555_5555_FFFF, 2'd1, 32'h8000_0000);   // R8 half upper kept
    send(64'hDEAD_BEEF_7FFF_FFFF, 2'd2, 32'h0000_0001);   // R8 word upper cleared
    send(64'h0123_4567_FFFF_FFFF, 2'd2, 32'h0000_00FF);   // R5 word zero
    send(64'h7FFF_FFFF_FFFF_FFFF, 2'd3, 32'h0000_0000);   // R4 sign 64
    send(64'hFFFF_FFFF_FFFF_FFFF, 2'd3, 32'hFFFF_FFFF);   // R2 carry kept
    send(64'h0000_0000_0000_0002, 2'd3, 32'h0000_0000);   // R7 parity of 03h
    idle(1);
    held_r = out_result; held_f = out_flags;
    idle(3);
    check(!out_valid, "R11 valid low when idle", 64'(out_valid), 64'd0);
    check(out_result == held_r && out_flags == held_f, "R11 outputs held",
          out_result, held_r);

    // random stream with gaps
    for (int k = 0; k < 400; k++) begin
      send({$urandom, $urandom}, 2'($urandom), $urandom);
      if ($urandom % 4 == 0) idle(1 + $urandom % 2);
    end
    idle(3);
    check(sb.size() == 0, "R10 all results delivered", 64'(sb.size()), 64'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule